// File: doc/BRIEF.md
# Multichannel SPI Master Register Front End

This block is the register-mapped control face of a multichannel SPI master with up to four channels. A simple single-cycle register bus reaches a small global register set (identity, system configuration, system status, module control) and one register bank per channel (configuration, status, control, transmit word, receive word). The configured state is presented to the channel shift engines on plain ports, and per-channel transmit and receive DMA request lines are formed from each channel's enable, its two DMA enable bits and the live buffer status reported by the engine.

A soft reset can be started by software through the system configuration register. It returns all channel state to zero, disables every channel, puts module control back to slave mode and, after a fixed number of cycles, reports completion through the system status register. Interrupt generation, wakeup logic and the shift engines themselves sit outside this block.

Top module: `spimc_regs`

## Requirements
- R1: A read of byte offset 0x00 returns the REV_ID parameter (default 0x00000021); read data appears on `bus_rdata` in the cycle after the request and holds until the next read.
- R2: Reads of unmapped offsets return zero and writes to them change nothing; unmapped includes 0x18, 0x1C, 0x20, 0x24, any offset with bits [1:0] non-zero, and any offset past the last channel bank.
- R3: Channel c's bank starts at 0x2C + 0x14*c with configuration at +0x0, status at +0x4, control at +0x8, transmit at +0xC and receive at +0x10; the configuration keeps bits [20:0] (upper bits read 0) and control bit 0 is the channel enable.
- R4: A status read returns receive-full in bit 0, transmit-empty in bit 1 and end-of-transfer in bit 2, taken from that channel's engine inputs.
- R5: A write to a channel's transmit register stores the word on `ch_tx_data_o` and pulses that channel's `ch_tx_load_o` for one cycle; a read of its receive register returns `ch_rx_data_i` and pulses that channel's `ch_rx_take_o` for one cycle.
- R6: A channel's transmit DMA request is high exactly when configuration bit 14, the channel enable and transmit-empty are all set.
- R7: A channel's receive DMA request is high exactly when configuration bit 15, the channel enable and receive-full are all set.
- R8: Module control at 0x28 resets to 0x4 (slave); bit 0 single-channel, bit 2 slave, bit 3 system test drive their outputs and all other bits read 0.
- R9: Writing bit 1 of system configuration (0x10) starts a soft reset lasting SRST_CYCLES cycles (default 8); during it 0x10 bit 1 reads 1 and system status (0x14) bit 0 reads 0, afterwards they read 0 and 1; after hardware reset 0x14 reads 1.
- R10: A soft reset clears every channel configuration, enable and transmit word, clears auto-idle, sets module control to 0x4, and bus writes made while it runs are ignored.
- R11: System configuration bit 0 is a stored auto-idle enable, read back at bit 0 and driven on `auto_idle_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| single_chan_o | output | 1 | Single-channel mode selected |
| slave_mode_o | output | 1 | Slave mode selected |
| sys_test_o | output | 1 | System test mode enabled |
| auto_idle_o | output | 1 | Auto-idle enable |
| ch_cfg_o | output | NCH*32 | Channel configurations, channel c at bits [32c+31:32c] |
| ch_en_o | output | NCH | Channel enables |
| ch_tx_data_o | output | NCH*32 | Stored transmit words |
| ch_tx_load_o | output | NCH | One-cycle pulse after a transmit write |
| ch_rx_data_i | input | NCH*32 | Received words from the engines |
| ch_rx_take_o | output | NCH | One-cycle pulse after a receive read |
| ch_rxs_i | input | NCH | Receive-full status |
| ch_txs_i | input | NCH | Transmit-empty status |
| ch_eot_i | input | NCH | End-of-transfer status |
| dma_tx_req_o | output | NCH | Transmit DMA requests |
| dma_rx_req_o | output | NCH | Receive DMA requests |

## Verification
The hardest situation to reach is a bus write that lands while a soft reset is still counting, because it must vanish without trace even though the decoder accepts it. The bench starts a soft reset, reads the busy and status bits back inside the reset window, then writes module control before the window closes and checks afterwards that the reset value 0x4 survived. The DMA request gating is walked by toggling one condition at a time (status input, configuration bit, enable) on a single channel and observing the request pin after each change.

// File: rtl/spimc_pkg.sv
// Shared offsets, bit positions and decode types for the SPI register front end.
// Assumes byte addressing with 32-bit word registers.
package spimc_pkg;
    localparam int OFF_REV     = 'h00;
    localparam int OFF_SYSCFG  = 'h10;
    localparam int OFF_SYSSTAT = 'h14;
    localparam int OFF_MODCTL  = 'h28;
    localparam int CH_BASE     = 'h2C;
    localparam int CH_STRIDE   = 'h14;

    localparam int CFG_BITS    = 21;   // configuration bits kept per channel
    localparam int BIT_DMA_WR  = 14;   // transmit DMA request enable
    localparam int BIT_DMA_RD  = 15;   // receive DMA request enable

    localparam logic [3:0] MODCTL_RESET = 4'b0100;   // slave mode

    typedef enum logic [2:0] {
        SEL_NONE, SEL_REV, SEL_SYSCFG, SEL_SYSSTAT, SEL_MODCTL, SEL_CHAN
    } sel_e;

    typedef enum logic [2:0] {
        CREG_CFG, CREG_STAT, CREG_CTRL, CREG_TX, CREG_RX
    } creg_e;
endpackage

// File: rtl/spimc_decode.sv
// Address decoder: maps a byte offset to a global register or to a channel
// bank entry. Assumes word-aligned accesses; misaligned offsets decode to none.
module spimc_decode
    import spimc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [CH_W-1:0]   ch,
    output creg_e             creg
);
    // Compare the offset against each global register and each channel window.
    always_comb begin
        int a;
        int rel;
        a    = int'(addr);
        sel  = SEL_NONE;
        ch   = '0;
        creg = CREG_CFG;
        rel  = 0;
        if (addr[1:0] == 2'b00) begin
            if (a == OFF_REV)          sel = SEL_REV;
            else if (a == OFF_SYSCFG)  sel = SEL_SYSCFG;
            else if (a == OFF_SYSSTAT) sel = SEL_SYSSTAT;
            else if (a == OFF_MODCTL)  sel = SEL_MODCTL;
            for (int c = 0; c < NCH; c++) begin
                if (a >= CH_BASE + CH_STRIDE * c && a < CH_BASE + CH_STRIDE * (c + 1)) begin
                    rel  = a - CH_BASE - CH_STRIDE * c;
                    sel  = SEL_CHAN;
                    ch   = CH_W'(c);
                    creg = creg_e'(3'(rel >> 2));
                end
            end
        end
    end
endmodule

// File: rtl/spimc_srst.sv
// Soft reset sequencer: on start, holds busy for SRST_CYCLES cycles, then
// raises done. Assumes start is ignored by the caller while busy.
module spimc_srst #(
    parameter int SRST_CYCLES = 8,
    localparam int CW = $clog2(SRST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    // Count the reset window and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b1;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(SRST_CYCLES - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_SRST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R9
    AST_SRST_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
endmodule

// File: rtl/spimc_chan.sv
// One channel bank: configuration, enable and transmit word registers plus
// the two DMA request lines. Assumes clr acts as a synchronous clear.
module spimc_chan
    import spimc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_cfg,
    input  logic        wr_ctrl,
    input  logic        wr_tx,
    input  logic [31:0] wdata,
    input  logic        txs,
    input  logic        rxs,
    output logic [31:0] cfg,
    output logic        en,
    output logic [31:0] tx_data,
    output logic        tx_load,
    output logic        dma_tx_req,
    output logic        dma_rx_req
);
    logic [CFG_BITS-1:0] cfg_q;

    // Hold the channel's configuration, enable and transmit word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg_q   <= '0;
            en      <= 1'b0;
            tx_data <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= wr_tx;
            if (wr_cfg)  cfg_q   <= wdata[CFG_BITS-1:0];
            if (wr_ctrl) en      <= wdata[0];
            if (wr_tx)   tx_data <= wdata;
        end
    end

    // Present the configuration and gate the DMA requests with live status.
    always_comb begin
        cfg        = {{(32 - CFG_BITS){1'b0}}, cfg_q};
        dma_tx_req = cfg_q[BIT_DMA_WR] && en && txs;
        dma_rx_req = cfg_q[BIT_DMA_RD] && en && rxs;
    end

    AST_TXREQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !clr && !wdata[BIT_DMA_WR]) |=> !dma_tx_req); // R6
    AST_RXREQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !clr && !wdata[0]) |=> !dma_rx_req); // R7
    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!en && cfg == 32'h0)); // R10
endmodule

// File: rtl/spimc_regs.sv
// Register front end of a multichannel SPI master: global registers, per-channel
// banks, soft reset and DMA request lines. Assumes one-cycle bus requests and
// registered read data one cycle later.
module spimc_regs
    import spimc_pkg::*;
#(
    parameter int          NCH         = 4,
    parameter int          ADDR_W      = 8,
    parameter int          SRST_CYCLES = 8,
    parameter logic [31:0] REV_ID      = 32'h0000_0021
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                single_chan_o,
    output logic                slave_mode_o,
    output logic                sys_test_o,
    output logic                auto_idle_o,
    output logic [NCH*32-1:0]   ch_cfg_o,
    output logic [NCH-1:0]      ch_en_o,
    output logic [NCH*32-1:0]   ch_tx_data_o,
    output logic [NCH-1:0]      ch_tx_load_o,
    input  logic [NCH*32-1:0]   ch_rx_data_i,
    output logic [NCH-1:0]      ch_rx_take_o,
    input  logic [NCH-1:0]      ch_rxs_i,
    input  logic [NCH-1:0]      ch_txs_i,
    input  logic [NCH-1:0]      ch_eot_i,
    output logic [NCH-1:0]      dma_tx_req_o,
    output logic [NCH-1:0]      dma_rx_req_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    sel_e            sel;
    creg_e           creg;
    logic [CH_W-1:0] ch;
    logic            we, rd;
    logic            srst_start, srst_busy, srst_done, srst_clr;
    logic [31:0]     rd_val;
    logic [31:0]     cfg_a [NCH];
    logic [31:0]     txd_a [NCH];

    spimc_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .addr(bus_addr), .sel(sel), .ch(ch), .creg(creg)
    );

    // Qualify accesses; writes are dropped while a soft reset runs.
    always_comb begin
        we         = bus_valid && bus_write && !srst_busy;
        rd         = bus_valid && !bus_write;
        srst_start = we && (sel == SEL_SYSCFG) && bus_wdata[1];
        srst_clr   = srst_start || srst_busy;
    end

    spimc_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst_n(rst_n), .start(srst_start),
        .busy(srst_busy), .done(srst_done)
    );

    // Global mode and auto-idle registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_clr) begin
            auto_idle_o   <= 1'b0;
            single_chan_o <= MODCTL_RESET[0];
            slave_mode_o  <= MODCTL_RESET[2];
            sys_test_o    <= MODCTL_RESET[3];
        end else if (we && sel == SEL_SYSCFG) begin
            auto_idle_o   <= bus_wdata[0];
        end else if (we && sel == SEL_MODCTL) begin
            single_chan_o <= bus_wdata[0];
            slave_mode_o  <= bus_wdata[2];
            sys_test_o    <= bus_wdata[3];
        end
    end

    // One bank instance per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = we && (sel == SEL_CHAN) && (ch == CH_W'(c));
        spimc_chan u_chan (
            .clk(clk), .rst_n(rst_n), .clr(srst_clr),
            .wr_cfg(hit && creg == CREG_CFG),
            .wr_ctrl(hit && creg == CREG_CTRL),
            .wr_tx(hit && creg == CREG_TX),
            .wdata(bus_wdata),
            .txs(ch_txs_i[c]), .rxs(ch_rxs_i[c]),
            .cfg(cfg_a[c]), .en(ch_en_o[c]),
            .tx_data(txd_a[c]), .tx_load(ch_tx_load_o[c]),
            .dma_tx_req(dma_tx_req_o[c]), .dma_rx_req(dma_rx_req_o[c])
        );
        assign ch_cfg_o[32*c +: 32]     = cfg_a[c];
        assign ch_tx_data_o[32*c +: 32] = txd_a[c];
    end

    // Select the read value for the decoded register.
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_REV:     rd_val = REV_ID;
            SEL_SYSCFG:  rd_val = {30'b0, srst_busy, auto_idle_o};
            SEL_SYSSTAT: rd_val = {31'b0, srst_done};
            SEL_MODCTL:  rd_val = {28'b0, sys_test_o, slave_mode_o, 1'b0, single_chan_o};
            SEL_CHAN: begin
                case (creg)
                    CREG_CFG:  rd_val = cfg_a[ch];
                    CREG_STAT: rd_val = {29'b0, ch_eot_i[ch], ch_txs_i[ch], ch_rxs_i[ch]};
                    CREG_CTRL: rd_val = {31'b0, ch_en_o[ch]};
                    CREG_TX:   rd_val = txd_a[ch];
                    CREG_RX:   rd_val = ch_rx_data_i[32*int'(ch) +: 32];
                    default:   rd_val = '0;
                endcase
            end
            default:     rd_val = '0;
        endcase
    end

    // Register read data and the receive-pop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata    <= '0;
            ch_rx_take_o <= '0;
        end else begin
            ch_rx_take_o <= '0;
            if (rd) begin
                bus_rdata <= rd_val;
                if (sel == SEL_CHAN && creg == CREG_RX) ch_rx_take_o[ch] <= 1'b1;
            end
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> (bus_rdata == 32'h0)); // R2
    AST_SRST_CHAN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (ch_en_o == '0)); // R10
    AST_SRST_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (slave_mode_o && !single_chan_o && !sys_test_o)); // R10
    AST_RX_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rx_take_o)); // R5
    AST_TX_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_tx_load_o)); // R5
endmodule

// File: tb/spimc_regs_bench.sv
module spimc_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NVEC = 14;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]          bus_addr = '0;
    logic [31:0]         bus_wdata = '0, bus_rdata;
    logic                single_chan_o, slave_mode_o, sys_test_o, auto_idle_o;
    logic [NCH*32-1:0]   ch_cfg_o, ch_tx_data_o;
    logic [NCH*32-1:0]   ch_rx_data_i = '0;
    logic [NCH-1:0]      ch_en_o, ch_tx_load_o, ch_rx_take_o;
    logic [NCH-1:0]      ch_rxs_i = '0, ch_txs_i = '0, ch_eot_i = '0;
    logic [NCH-1:0]      dma_tx_req_o, dma_rx_req_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spimc_regs u_spimc_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .single_chan_o(single_chan_o), .slave_mode_o(slave_mode_o),
        .sys_test_o(sys_test_o), .auto_idle_o(auto_idle_o),
        .ch_cfg_o(ch_cfg_o), .ch_en_o(ch_en_o), .ch_tx_data_o(ch_tx_data_o),
        .ch_tx_load_o(ch_tx_load_o), .ch_rx_data_i(ch_rx_data_i),
        .ch_rx_take_o(ch_rx_take_o), .ch_rxs_i(ch_rxs_i), .ch_txs_i(ch_txs_i),
        .ch_eot_i(ch_eot_i), .dma_tx_req_o(dma_tx_req_o), .dma_rx_req_o(dma_rx_req_o)
    );

    // {req number, is write, offset, write data, expected read-back}
    localparam logic [76:0] VEC [NVEC] = '{
        {4'd1,  1'b0, 8'h00, 32'h0,         32'h0000_0021}, // R1 identity
        {4'd9,  1'b0, 8'h14, 32'h0,         32'h0000_0001}, // R9 done after hw reset
        {4'd8,  1'b0, 8'h28, 32'h0,         32'h0000_0004}, // R8 slave default
        {4'd8,  1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0000_000D}, // R8 only mode bits
        {4'd3,  1'b1, 8'h2C, 32'hFFFF_FFFF, 32'h001F_FFFF}, // R3 cfg width
        {4'd3,  1'b1, 8'h68, 32'h0000_C003, 32'h0000_C003}, // R3 ch3 cfg
        {4'd2,  1'b1, 8'h18, 32'h0000_FFFF, 32'h0},         // R2 reserved
        {4'd2,  1'b1, 8'h24, 32'h0000_FFFF, 32'h0},         // R2 reserved
        {4'd2,  1'b0, 8'h7C, 32'h0,         32'h0},         // R2 past last bank
        {4'd2,  1'b1, 8'h2E, 32'h0000_0005, 32'h0},         // R2 misaligned
        {4'd11, 1'b1, 8'h10, 32'h0000_0001, 32'h0000_0001}, // R11 auto-idle
        {4'd3,  1'b1, 8'h34, 32'h0000_0001, 32'h0000_0001}, // R3 ch0 enable
        {4'd5,  1'b1, 8'h4C, 32'h0000_A5A5, 32'h0000_A5A5}, // R5 ch1 tx word
        {4'd2,  1'b0, 8'h2C, 32'h0,         32'h001F_FFFF}  // R2 misaligned write left ch0 cfg
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R1 read data idle, R8 slave mode, R6/R7 requests low
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R8 mode outputs after reset", {28'b0, sys_test_o, slave_mode_o, 1'b0, single_chan_o}, 32'h4);
        check("R6 tx req after reset", {28'b0, dma_tx_req_o}, 32'h0);
        check("R7 rx req after reset", {28'b0, dma_rx_req_o}, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][72]) bus_wr(VEC[i][71:64], VEC[i][63:32]);
            bus_rd(VEC[i][71:64], r);
            n_checks++;
            if (r !== VEC[i][31:0]) begin
                n_fails++;
                $display("FAIL R%0d vector %0d offset %h: actual %h expected %h",
                         VEC[i][76:73], i, VEC[i][71:64], r, VEC[i][31:0]);
            end
        end
        check("R8 mode outputs", {28'b0, sys_test_o, slave_mode_o, 1'b0, single_chan_o}, 32'hD);
        check("R11 auto_idle_o", {31'b0, auto_idle_o}, 32'h1);
        check("R3 ch0 cfg port", ch_cfg_o[31:0], 32'h001F_FFFF);

        // R6: ch0 enabled with both DMA enables; toggle transmit-empty
        ch_txs_i[0] = 1'b1; @(negedge clk);
        check("R6 tx req with all conditions", {28'b0, dma_tx_req_o}, 32'h1);
        ch_txs_i[0] = 1'b0; @(negedge clk);
        check("R6 tx req without tx-empty", {28'b0, dma_tx_req_o}, 32'h0);
        ch_txs_i[0] = 1'b1;
        bus_wr(8'h2C, 32'h0000_8000);
        check("R6 tx req with bit14 clear", {28'b0, dma_tx_req_o}, 32'h0);
        // R7: only bit15 set now
        check("R7 rx req without rx-full", {28'b0, dma_rx_req_o}, 32'h0);
        ch_rxs_i[0] = 1'b1; @(negedge clk);
        check("R7 rx req with all conditions", {28'b0, dma_rx_req_o}, 32'h1);
        bus_wr(8'h34, 32'h0);
        check("R7 rx req with channel disabled", {28'b0, dma_rx_req_o}, 32'h0);
        ch_rxs_i[0] = 1'b0; ch_txs_i[0] = 1'b0;

        // R4: ch1 status bits
        ch_rxs_i[1] = 1'b1; ch_eot_i[1] = 1'b1;
        bus_rd(8'h44, r);
        check("R4 ch1 status rx-full and eot", r, 32'h5);
        ch_rxs_i[1] = 1'b0; ch_eot_i[1] = 1'b0; ch_txs_i[1] = 1'b1;
        bus_rd(8'h44, r);
        check("R4 ch1 status tx-empty", r, 32'h2);
        ch_txs_i[1] = 1'b0;

        // R5: transmit load on ch2 only, one cycle
        bus_wr(8'h60, 32'h0000_1234);
        check("R5 tx load pulse", {28'b0, ch_tx_load_o}, 32'h4);
        check("R5 ch2 tx word", ch_tx_data_o[64 +: 32], 32'h0000_1234);
        @(negedge clk);
        check("R5 tx load ends", {28'b0, ch_tx_load_o}, 32'h0);
        // R5: receive pop on ch3
        ch_rx_data_i[96 +: 32] = 32'h0000_BEEF;
        bus_rd(8'h78, r);
        check("R5 ch3 rx word", r, 32'h0000_BEEF);
        check("R5 rx take pulse", {28'b0, ch_rx_take_o}, 32'h8);
        @(negedge clk);
        check("R5 rx take ends", {28'b0, ch_rx_take_o}, 32'h0);

        // R9/R10: soft reset with a write attempted inside the window
        bus_wr(8'h10, 32'h0000_0003);
        check("R10 channels off in soft reset", {28'b0, ch_en_o}, 32'h0);
        bus_rd(8'h10, r);
        check("R9 busy bit during soft reset", r, 32'h2);
        bus_rd(8'h14, r);
        check("R9 status during soft reset", r, 32'h0);
        bus_wr(8'h28, 32'h0000_0009);
        repeat (12) @(negedge clk);
        bus_rd(8'h14, r);
        check("R9 status after soft reset", r, 32'h1);
        bus_rd(8'h10, r);
        check("R9 sysconfig after soft reset", r, 32'h0);
        bus_rd(8'h28, r);
        check("R10 write in window ignored", r, 32'h4);
        bus_rd(8'h68, r);
        check("R10 ch3 cfg cleared", r, 32'h0);
        check("R10 tx words cleared", ch_tx_data_o[95:0] == '0 ? 32'h0 : 32'h1, 32'h0);
        check("R11 auto-idle cleared", {31'b0, auto_idle_o}, 32'h0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule